// File: doc/BRIEF.md
# GPIO Port With Change Interrupt

This block is an 8-bit general-purpose I/O port with a small register bank. Each pin can be set as an input or an output. Output pins drive a value held in an output data register. Input pins are read through a per-pin polarity-inversion mask. The pin side has three separate vectors: sampled inputs, output values and output enables. A board or pad ring can combine them into bidirectional pads.

Inputs pass through a two-stage synchroniser. The interrupt compares the synchronised levels of the input pins against a snapshot. The snapshot is taken at reset and on every read of the input register. The interrupt is level-based, not sticky. It drops when every input pin returns to its snapshot value, or when the input register is read. It appears as an active-high enable that pulls an active-low, open-drain-style line low.

Top module: `gpio_chgint_port`

## Requirements
- R1: While `rst_n` is low at a rising edge, the port resets. Every pin becomes an input (`pin_oe` = 00). The output register becomes FF. The polarity register becomes 00. The snapshot loads the current `pin_in`. `irq_pull_low` is 0.
- R2: A write to address 3 sets the direction register: bit value 1 = input, 0 = output. From the next cycle, `pin_oe` is the bitwise inverse of the direction register.
- R3: A write to address 1 sets the output register. From the next cycle, `pin_out` equals it.
- R4: Address 0 reads the synchronised pins XOR the polarity register (address 2). A pin change appears in this value after two rising edges.
- R5: `irq_pull_low` is 1 when any input-configured pin's synchronised level differs from the snapshot.
- R6: `irq_pull_low` returns to 0 when every input pin goes back to its snapshot value.
- R7: While `reg_rd` is high with address 0, `irq_pull_low` is 0 in that same cycle. The snapshot takes the current synchronised pins, so the interrupt stays clear afterwards while the pins hold.
- R8: Pins configured as outputs never raise the interrupt, whatever their input level.
- R9: Switching a pin from output to input raises the interrupt in the next cycle if its level differs from the snapshot.
- R10: Writes to address 0 change no register.
- R11: `reg_rdata` is combinational from `reg_addr`. Addresses 1, 2 and 3 return the output, polarity and direction registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (side effect only on address 0) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data |
| pin_in | input | 8 | Sampled pin levels |
| pin_out | output | 8 | Output drive values |
| pin_oe | output | 8 | Output enables, 1 = drive |
| irq_pull_low | output | 1 | 1 = pull the active-low interrupt line low |

## Verification
The hardest case to reach is an interrupt caused only by reconfiguration, with no pin edge involved. It needs a pin to move while it is an output, and the snapshot must still hold the old value. The stimulus sets a pin to output, toggles that pin's input with no read in between, and confirms the interrupt stays quiet. It then turns the pin back into an input and expects the interrupt on the following cycle. The same per-pin sweep also covers clearing by return, clearing by read, and the snapshot shift that a read causes.

// File: rtl/gpio_chgint_port.sv
module gpio_chgint_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   reg_addr,
  input  logic         reg_wr,
  input  logic         reg_rd,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic         irq_pull_low
);
  localparam logic [1:0] A_IN = 2'd0, A_OUT = 2'd1, A_POL = 2'd2, A_DIR = 2'd3;

  logic [W-1:0] meta, sync, snap, outr, pol, dir;
  logic         rd_in;

  assign rd_in = reg_rd && (reg_addr == A_IN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta <= pin_in;
      sync <= pin_in;
      snap <= pin_in;
      outr <= '1;
      pol  <= '0;
      dir  <= '1;
    end else begin
      meta <= pin_in;
      sync <= meta;
      if (rd_in) snap <= sync;
      if (reg_wr) begin
        case (reg_addr)
          A_OUT:   outr <= reg_wdata;
          A_POL:   pol  <= reg_wdata;
          A_DIR:   dir  <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_OUT:   reg_rdata = outr;
      A_POL:   reg_rdata = pol;
      A_DIR:   reg_rdata = dir;
      default: reg_rdata = sync ^ pol;
    endcase
  end

  assign pin_out      = outr;
  assign pin_oe       = ~dir;
  assign irq_pull_low = (|((sync ^ snap) & dir)) && !rd_in;

  a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(reg_wr && reg_addr == A_DIR)) |-> (pin_oe == ~$past(reg_wdata)));
  a_r3_out_write: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(reg_wr && reg_addr == A_OUT)) |-> (pin_out == $past(reg_wdata)));
  a_r8_all_outputs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe == '1) |-> !irq_pull_low);
  a_r7_read_rearms: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rd_in) && sync == $past(sync)) |-> !irq_pull_low);
  a_r7_read_masks: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_IN) |-> !irq_pull_low);
endmodule

// File: tb/sim_gpio_chgint_port.sv
module sim_gpio_chgint_port;
  logic       clk = 0, rst_n = 0, reg_wr = 0, reg_rd = 0, irq_pull_low;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata, pin_in = 8'h5A, pin_out, pin_oe;
  int checks = 0, fails = 0;

  gpio_chgint_port u0 (.clk, .rst_n, .reg_addr, .reg_wr, .reg_rd, .reg_wdata,
    .reg_rdata, .pin_in, .pin_out, .pin_oe, .irq_pull_low);

  always #2 clk = ~clk;

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1; tick(); reg_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d, output logic irq);
    reg_addr = a; reg_rd = 1; #1; d = reg_rdata; irq = irq_pull_low; tick(); reg_rd = 0;
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h1, 8'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d, pv;
    logic q;
    repeat (3) tick();
    rst_n = 1;
    chk("R1 oe", pin_oe, 8'h00);
    chk("R1 out", pin_out, 8'hFF);
    chk("R1 irq", {7'd0, irq_pull_low}, 8'h00);
    rd(2, d, q); chk("R1 pol", d, 8'h00);
    rd(3, d, q); chk("R1 dir", d, 8'hFF);
    rd(0, d, q); chk("R1 input", d, 8'h5A);

    for (int v = 0; v < 256; v += 17) begin
      wr(1, v[7:0]);
      chk("R3 pin_out", pin_out, v[7:0]);
      rd(1, d, q); chk("R11 out readback", d, v[7:0]);
    end

    for (int v = 0; v < 256; v++) begin
      pv = 8'(v * 37 + 11);
      pin_in = v[7:0];
      wr(2, pv);
      tick();
      rd(0, d, q); chk("R4 inverted read", d, v[7:0] ^ pv);
    end
    rd(2, d, q); chk("R11 pol readback", d, 8'(255 * 37 + 11));

    wr(2, 8'h00); wr(3, 8'h0F); wr(1, 8'h3C);
    wr(0, 8'hAA);
    rd(1, d, q); chk("R10 out kept", d, 8'h3C);
    rd(2, d, q); chk("R10 pol kept", d, 8'h00);
    rd(3, d, q); chk("R10 dir kept", d, 8'h0F);
    chk("R2 oe", pin_oe, 8'hF0);
    rd(0, d, q); chk("R10 input unaffected", d, 8'hFF);

    pin_in = 8'hA5; wr(3, 8'hFF); tick(); tick();
    rd(0, d, q);
    for (int i = 0; i < 8; i++) begin
      logic [7:0] m, b;
      m = 8'(1 << i); b = 8'hA5;
      pin_in = b ^ m; tick(); tick();
      chk("R5 irq on change", {7'd0, irq_pull_low}, 8'h01);
      pin_in = b; tick(); tick();
      chk("R6 irq on return", {7'd0, irq_pull_low}, 8'h00);
      pin_in = b ^ m; tick(); tick();
      rd(0, d, q);
      chk("R7 cleared in read cycle", {7'd0, q}, 8'h00);
      chk("R4 read value", d, b ^ m);
      chk("R7 stays clear", {7'd0, irq_pull_low}, 8'h00);
      pin_in = b; tick(); tick();
      chk("R7 snapshot moved", {7'd0, irq_pull_low}, 8'h01);
      rd(0, d, q);
      wr(3, ~m);
      chk("R2 oe bit", pin_oe, m);
      pin_in = b ^ m; tick(); tick();
      chk("R8 output pin excluded", {7'd0, irq_pull_low}, 8'h00);
      wr(3, 8'hFF);
      chk("R9 output-to-input raises", {7'd0, irq_pull_low}, 8'h01);
      rd(0, d, q);
      pin_in = b; tick(); tick();
      rd(0, d, q);
      chk("R7 clear at end", {7'd0, irq_pull_low}, 8'h00);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule